// File: doc/BRIEF.md
# Supervised Processor Reset Generator

This block drives the active-low reset of a processor from one digital undervoltage flag, which an external comparator is expected to produce, and from an active-low manual reset request. Either input counts as a fault. From power-on the reset output is held low. It is released only after the fault has been absent for a programmed number of clock cycles without a break. Once the reset is released, the block ignores a fault that lasts fewer than a programmed number of cycles. A longer fault pulls the reset low again, and a full release period must then run before the reset is released a second time.

Both inputs pass through a two-flop synchroniser before they reach the controller. The controller is a four-state machine:
- `ST_HOLD` keeps the reset asserted while a fault is present.
- `ST_COUNT` runs the release countdown.
- `ST_RUN` is normal operation with the reset released.
- `ST_FILTER` counts a fault that has begun while the reset is released.

The transitions are:
- hold→count when the fault clears.
- count→hold on any fault.
- count→run when the period expires.
- run→filter on a fault when the filter length is 2 or more.
- run→hold on a fault when the filter length is 0 or 1.
- filter→run when the fault clears early.
- filter→hold when the fault has been seen for the full filter length.

The period and the filter length are captured on clock edges while the power-on reset is low.

Top module: `rst_supervisor`

## Requirements
- R1: While `por_n` is low, and from then on while a fault persists, `rst_out_n` is 0. A fault is `supply_low`=1 or `man_rst_n`=0.
- R2: With period P captured, where a value of 0 acts as 1, `rst_out_n` rises at the (P+3)th rising clock edge. The count starts with the first edge at which the fault-free input is applied, or the first edge after `por_n` rises if the input is already good. It is still 0 after P+2 edges.
- R3: While the reset is released, a fault that covers fewer than F consecutive clock edges leaves `rst_out_n` at 1. F is the captured filter length.
- R4: A fault that covers F edges (F≥2) drives `rst_out_n` to 0 at the (F+2)th edge from its onset. Release then needs a new full period, as in R2.
- R5: `man_rst_n`=0 is handled exactly like `supply_low`=1, including the filter and the release period.
- R6: A fault seen during the release countdown sends the block back to the held state. The full period restarts once the fault clears. No filter delay applies while the reset is asserted.
- R7: `period_cfg` and `filter_cfg` are sampled only on edges with `por_n` low. Changes while `por_n` is high have no effect until the next power-on reset.
- R8: With a filter length of 0 or 1, a single-edge fault after release drives `rst_out_n` low at the 3rd edge from its onset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| supply_low | input | 1 | Undervoltage flag from the comparator, 1 = supply bad |
| man_rst_n | input | 1 | Manual reset request, active low |
| period_cfg | input | CNT_W | Release period in cycles, captured during power-on reset |
| filter_cfg | input | CNT_W | Minimum fault length in cycles, captured during power-on reset |
| rst_out_n | output | 1 | Processor reset, active low |

## Verification
Every input change reaches the controller two edges late because of the synchroniser, and the output is a state-register bit. A release is therefore due P+3 edges after the input becomes good, and a filtered fault takes effect F+2 edges after its onset. The bench changes inputs on falling edges, advances an exact number of rising edges for each table row, and samples on the following falling edge. Each boundary is checked on both sides: one edge before the output is due to move, and on the edge where it moves.

// File: rtl/rsup_pkg.sv
package rsup_pkg;
    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_COUNT  = 2'd1,
        ST_RUN    = 2'd2,
        ST_FILTER = 2'd3
    } rsup_state_e;
endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
    parameter int         W       = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q_o    <= RST_VAL;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/rsup_cnt.sv
module rsup_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_o <= '0;
        else if (clr_i)  cnt_o <= '0;
        else if (inc_i)  cnt_o <= cnt_o + W'(1);
    end
endmodule

// File: rtl/rsup_fsm.sv
module rsup_fsm
    import rsup_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             fault_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] filter_i,
    output logic             clr_o,
    output logic             inc_o,
    output logic             rst_n_o
);
    localparam int EW = CNT_W + 1;

    rsup_state_e state_q, state_d;
    logic [EW-1:0] cnt_plus;
    logic          period_done, filter_done, filter_short;

    assign cnt_plus     = {1'b0, cnt_i} + EW'(1);
    assign period_done  = cnt_plus >= {1'b0, period_i};
    assign filter_done  = cnt_plus >= {1'b0, filter_i};
    assign filter_short = filter_i <= CNT_W'(1);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        clr_o   = 1'b1;
        inc_o   = 1'b0;
        unique case (state_q)
            ST_HOLD: begin
                if (!fault_i) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (fault_i)          state_d = ST_HOLD;
                else if (period_done) state_d = ST_RUN;
                else begin
                    clr_o = 1'b0;
                    inc_o = 1'b1;
                end
            end
            ST_RUN: begin
                if (fault_i) begin
                    if (filter_short) state_d = ST_HOLD;
                    else begin
                        state_d = ST_FILTER;
                        clr_o   = 1'b0;
                        inc_o   = 1'b1;
                    end
                end
            end
            ST_FILTER: begin
                if (!fault_i)         state_d = ST_RUN;
                else if (filter_done) state_d = ST_HOLD;
                else begin
                    clr_o = 1'b0;
                    inc_o = 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_RUN, ST_FILTER: rst_n_o = 1'b1;
            ST_HOLD, ST_COUNT: rst_n_o = 1'b0;
        endcase
    end

    // R2
    release_after_period_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_n_o) |-> (!$past(fault_i) && ({1'b0, $past(cnt_i)} + EW'(1) >= {1'b0, $past(period_i)})));

    // R4
    assert_only_on_fault_chk: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_n_o) |-> $past(fault_i));

    // R3
    released_holds_chk: assert property (@(posedge clk) disable iff (!por_n)
        (rst_n_o && !fault_i) |=> rst_n_o);

    // R6
    held_stays_on_fault_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_n_o && fault_i) |=> !rst_n_o);
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             supply_low,
    input  logic             man_rst_n,
    input  logic [CNT_W-1:0] period_cfg,
    input  logic [CNT_W-1:0] filter_cfg,
    output logic             rst_out_n
);
    localparam int NSRC = 2;

    logic [NSRC-1:0]  raw_fault, sync_fault;
    logic             fault;
    logic [CNT_W-1:0] period_q, filter_q, cnt;
    logic             cnt_clr, cnt_inc;

    assign raw_fault = {supply_low, ~man_rst_n};

    always_ff @(posedge clk) begin
        if (!por_n) begin
            period_q <= period_cfg;
            filter_q <= filter_cfg;
        end
    end

    rsup_sync #(.W(NSRC), .RST_VAL({NSRC{1'b1}})) u_sync (
        .clk   (clk),
        .rst_n (por_n),
        .d_i   (raw_fault),
        .q_o   (sync_fault)
    );

    assign fault = |sync_fault;

    rsup_cnt #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (por_n),
        .clr_i (cnt_clr),
        .inc_i (cnt_inc),
        .cnt_o (cnt)
    );

    rsup_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .por_n    (por_n),
        .fault_i  (fault),
        .cnt_i    (cnt),
        .period_i (period_q),
        .filter_i (filter_q),
        .clr_o    (cnt_clr),
        .inc_o    (cnt_inc),
        .rst_n_o  (rst_out_n)
    );

    // R7
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!por_n)
        $stable(period_q) && $stable(filter_q));

    // R1
    held_in_por_chk: assert property (@(posedge clk)
        !por_n |-> !rst_out_n);
endmodule

// File: tb/test_rst_supervisor.sv
module test_rst_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int NVEC       = 19;

    typedef struct packed {
        logic       bad;
        logic       man_n;
        logic [7:0] edges;
        logic       exp;
        logic [3:0] req;
    } vec_t;

    // Table assumes period 6 and filter 4 captured at power-on reset.
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b1, 8'd20, 1'b0, 4'd1}, // R1 fault persists after POR
        '{1'b0, 1'b1, 8'd8,  1'b0, 4'd2}, // R2 one edge early
        '{1'b0, 1'b1, 8'd1,  1'b1, 4'd2}, // R2 released, R7 old period used
        '{1'b1, 1'b1, 8'd3,  1'b1, 4'd3}, // R3 dip of F-1
        '{1'b0, 1'b1, 8'd5,  1'b1, 4'd3}, // R3 dip ignored, R7 old filter used
        '{1'b1, 1'b1, 8'd4,  1'b1, 4'd4}, // R4 dip of F
        '{1'b0, 1'b1, 8'd1,  1'b1, 4'd4}, // R4 not yet
        '{1'b0, 1'b1, 8'd1,  1'b0, 4'd4}, // R4 asserted at F+2
        '{1'b0, 1'b1, 8'd6,  1'b0, 4'd4}, // R4 new period running
        '{1'b0, 1'b1, 8'd1,  1'b1, 4'd4}, // R4 released again
        '{1'b0, 1'b0, 8'd5,  1'b1, 4'd5}, // R5 manual filtered
        '{1'b0, 1'b0, 8'd1,  1'b0, 4'd5}, // R5 manual asserts
        '{1'b0, 1'b1, 8'd8,  1'b0, 4'd5}, // R5 period after manual
        '{1'b0, 1'b1, 8'd1,  1'b1, 4'd5}, // R5 released
        '{1'b1, 1'b1, 8'd10, 1'b0, 4'd6}, // R6 long fault
        '{1'b0, 1'b1, 8'd4,  1'b0, 4'd6}, // R6 countdown part way
        '{1'b1, 1'b1, 8'd1,  1'b0, 4'd6}, // R6 one-edge fault in countdown
        '{1'b0, 1'b1, 8'd8,  1'b0, 4'd6}, // R6 countdown restarted
        '{1'b0, 1'b1, 8'd1,  1'b1, 4'd6}  // R6 released
    };

    logic             clk = 1'b0;
    logic             por_n;
    logic             supply_low;
    logic             man_rst_n;
    logic [CNT_W-1:0] period_cfg;
    logic [CNT_W-1:0] filter_cfg;
    logic             rst_out_n;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_supervisor #(.CNT_W(CNT_W)) i_rst_supervisor (
        .clk        (clk),
        .por_n      (por_n),
        .supply_low (supply_low),
        .man_rst_n  (man_rst_n),
        .period_cfg (period_cfg),
        .filter_cfg (filter_cfg),
        .rst_out_n  (rst_out_n)
    );

    task automatic check(input logic exp, input string req, input string what);
        n_tests++;
        if (rst_out_n !== exp) begin
            n_fail++;
            $display("FAIL %s %s: rst_out_n=%b expected %b", req, what, rst_out_n, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        por_n      = 1'b0;
        supply_low = 1'b1;
        man_rst_n  = 1'b1;
        period_cfg = CNT_W'(6);
        filter_cfg = CNT_W'(4);
        step(3);
        check(1'b0, "R1", "during power-on reset");
        por_n      = 1'b1;
        // R7: new values while por_n is high must be ignored
        period_cfg = CNT_W'(2);
        filter_cfg = CNT_W'(1);

        for (int i = 0; i < NVEC; i++) begin
            supply_low = VECS[i].bad;
            man_rst_n  = VECS[i].man_n;
            step(int'(VECS[i].edges));
            check(VECS[i].exp, $sformatf("R%0d", VECS[i].req), $sformatf("vector %0d", i));
        end

        // Second power-on reset: period 2, filter 1, supply already good
        por_n      = 1'b0;
        supply_low = 1'b0;
        man_rst_n  = 1'b1;
        step(3);
        check(1'b0, "R1", "second power-on reset");
        por_n = 1'b1;
        step(4);
        check(1'b0, "R2", "period 2 one edge early");
        step(1);
        check(1'b1, "R7", "period 2 captured at POR");

        // R8: single-edge fault with filter length 1
        supply_low = 1'b1;
        step(1);
        check(1'b1, "R8", "glitch edge 1");
        supply_low = 1'b0;
        step(1);
        check(1'b1, "R8", "glitch edge 2");
        step(1);
        check(1'b0, "R8", "glitch asserts at edge 3");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule